// File: doc/BRIEF.md
# Converter Power-State and Wake-Up Controller

This block decides the power state of a sampling converter. Two inputs drive it. The active-low shutdown input `shdn_n` puts the converter into a low-power state. The active-low select input `cs_n` sets how deep that state is. A light state (nap) keeps the reference running and turns the other bias off. A deep state (sleep) turns off all bias, the reference included. The select input is sampled on every cycle while shutdown is held, so the depth can change at any time.

When shutdown is released, the block enters a wake state and counts a wake-up delay in clock cycles. It stays in wake until the count has run out, and only then raises `ready`. The `ready` flag gates conversion start requests, and a request made before `ready` is lost. A nap recovery uses the short delay. Any recovery that follows a period with the reference turned off uses the long delay. Releasing the reset is also treated as a cold start of the reference.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: When `shdn_n` is sampled low at a clock edge, the state after that edge is nap or sleep, `ready` is 0 and `conv_start` is 0, whatever state the block was in before.
- R2: While `shdn_n` is low, `cs_n` is sampled at every edge. `cs_n`=0 gives nap and `cs_n`=1 gives sleep. Nap can move to sleep and sleep can move back to nap without leaving shutdown. The `pwr_mode` codes are: 00 active, 01 nap, 10 sleep, 11 wake.
- R3: The domain enables depend only on the state:
  - active: `ref_en`=1, `bias_en`=1, `ready`=1
  - nap: `ref_en`=1, `bias_en`=0, `ready`=0
  - sleep: `ref_en`=0, `bias_en`=0, `ready`=0
  - wake: `ref_en`=1, `bias_en`=1, `ready`=0
- R4: A nap can exit with the reference warm. In that case, the edge that samples `shdn_n` high enters wake. Wake lasts exactly `NAP_WAKE_CYC` cycles, and then the block is active.
- R5: An exit from sleep lasts exactly `SLEEP_WAKE_CYC` wake cycles before the block is active.
- R6: If `shdn_n` is sampled low during wake, the wake is abandoned and the state selected by `cs_n` is entered at that edge. A later exit restarts the full delay.
- R7: The reference stays cold from any entry into sleep until a wake has completed. A wake that begins during that time uses `SLEEP_WAKE_CYC`, even when it starts from nap.
- R8: While reset is asserted, the block is in wake with a cold reference. With `shdn_n` held high, it becomes active at the `SLEEP_WAKE_CYC`-th rising edge after reset is released.
- R9: `conv_start` equals `start_req` AND `ready` in the same cycle. A request made while the block is not ready produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n | input | 1 | Active-low shutdown request |
| cs_n | input | 1 | Active-low select; sets the shutdown depth |
| start_req | input | 1 | Conversion start request |
| pwr_mode | output | 2 | Current state code (00 active, 01 nap, 10 sleep, 11 wake) |
| bias_en | output | 1 | Enable for the analog bias domain |
| ref_en | output | 1 | Enable for the reference domain |
| ready | output | 1 | Conversions allowed |
| conv_start | output | 1 | Start request passed on to the sequencer |

## Verification
The properties assume that `shdn_n` and `cs_n` are synchronous to `clk` and stable around each rising edge. They also assume `NAP_WAKE_CYC` is at least 1 and no greater than `SLEEP_WAKE_CYC`. The bench changes every input only on falling edges, so each value is steady when the next rising edge samples it. The bench uses delays of 4 and 20 cycles, so the short and long waits are both short enough to count edge by edge and clearly different from each other.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    PM_ACTIVE = 2'b00,
    PM_NAP    = 2'b01,
    PM_SLEEP  = 2'b10,
    PM_WAKE   = 2'b11
  } pm_e;

  typedef struct packed {
    logic ref_on;
    logic bias_on;
    logic rdy;
  } dom_t;

  // Domain enables that belong to each state
  function automatic dom_t domains_for(pm_e m);
    dom_t d;
    case (m)
      PM_ACTIVE: d = '{ref_on: 1'b1, bias_on: 1'b1, rdy: 1'b1};
      PM_NAP:    d = '{ref_on: 1'b1, bias_on: 1'b0, rdy: 1'b0};
      PM_SLEEP:  d = '{ref_on: 1'b0, bias_on: 1'b0, rdy: 1'b0};
      default:   d = '{ref_on: 1'b1, bias_on: 1'b1, rdy: 1'b0};
    endcase
    return d;
  endfunction

  // Depth of shutdown picked by the select input
  function automatic pm_e low_mode_for(logic sel_n);
    return sel_n ? PM_SLEEP : PM_NAP;
  endfunction

endpackage

// File: rtl/pwr_wake_timer.sv
`timescale 1ns/1ps
module pwr_wake_timer #(
  parameter int CW        = 8,
  parameter int RESET_VAL = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  output logic          expire
);

  localparam logic [CW-1:0] RST_CNT = CW'(RESET_VAL);
  localparam logic [CW-1:0] ONE     = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= RST_CNT;
    else if (load)                cnt_q <= load_val;
    else if (run && cnt_q != '0)  cnt_q <= cnt_q - ONE;
  end

  assign expire = run && (cnt_q == ONE);

endmodule

// File: rtl/pwr_next_state.sv
`timescale 1ns/1ps
module pwr_next_state
  import pwr_seq_pkg::*;
(
  input  pm_e  cur,
  input  logic shdn_n,
  input  logic cs_n,
  input  logic expire,
  output pm_e  nxt,
  output logic load
);

  always_comb begin
    nxt  = cur;
    load = 1'b0;
    if (!shdn_n) begin
      nxt = low_mode_for(cs_n);
    end else begin
      case (cur)
        PM_NAP, PM_SLEEP: begin
          nxt  = PM_WAKE;
          load = 1'b1;
        end
        PM_WAKE: if (expire) nxt = PM_ACTIVE;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pwr_domain_drive.sv
`timescale 1ns/1ps
module pwr_domain_drive
  import pwr_seq_pkg::*;
(
  input  pm_e         cur,
  input  logic        start_req,
  output logic [1:0]  mode_code,
  output logic        ref_en,
  output logic        bias_en,
  output logic        ready,
  output logic        conv_start
);

  dom_t d;

  always_comb begin
    d          = domains_for(cur);
    mode_code  = cur;
    ref_en     = d.ref_on;
    bias_en    = d.bias_on;
    ready      = d.rdy;
    conv_start = start_req & d.rdy;
  end

endmodule

// File: rtl/pwr_seq_ctrl.sv
`timescale 1ns/1ps
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int NAP_WAKE_CYC   = 10,
  parameter int SLEEP_WAKE_CYC = 8000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shdn_n,
  input  logic       cs_n,
  input  logic       start_req,
  output logic [1:0] pwr_mode,
  output logic       bias_en,
  output logic       ref_en,
  output logic       ready,
  output logic       conv_start
);

  localparam int CW = $clog2(SLEEP_WAKE_CYC + 1);

  function automatic logic [CW-1:0] wake_len(logic warm);
    return warm ? CW'(NAP_WAKE_CYC) : CW'(SLEEP_WAKE_CYC);
  endfunction

  pm_e  state_q, state_d;
  logic ref_warm_q;
  logic timer_load;
  logic timer_expire;
  logic wake_done;
  logic enter_sleep;

  pwr_wake_timer #(
    .CW        (CW),
    .RESET_VAL (SLEEP_WAKE_CYC)
  ) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (wake_len(ref_warm_q)),
    .run      (state_q == PM_WAKE),
    .expire   (timer_expire)
  );

  pwr_next_state ns_i (
    .cur    (state_q),
    .shdn_n (shdn_n),
    .cs_n   (cs_n),
    .expire (timer_expire),
    .nxt    (state_d),
    .load   (timer_load)
  );

  assign wake_done   = (state_q == PM_WAKE) && (state_d == PM_ACTIVE);
  assign enter_sleep = (state_d == PM_SLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PM_WAKE;
      ref_warm_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (enter_sleep)    ref_warm_q <= 1'b0;
      else if (wake_done) ref_warm_q <= 1'b1;
    end
  end

  pwr_domain_drive drv_i (
    .cur        (state_q),
    .start_req  (start_req),
    .mode_code  (pwr_mode),
    .ref_en     (ref_en),
    .bias_en    (bias_en),
    .ready      (ready),
    .conv_start (conv_start)
  );

endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_chk #(
  parameter int NAP_WAKE_CYC   = 10,
  parameter int SLEEP_WAKE_CYC = 8000000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       shdn_n,
  input logic       cs_n,
  input logic       start_req,
  input logic [1:0] pwr_mode,
  input logic       bias_en,
  input logic       ref_en,
  input logic       ready,
  input logic       conv_start,
  input logic       wake_done
);

  localparam int CW = $clog2(SLEEP_WAKE_CYC + 2);
  localparam logic [1:0] C_ACT = 2'b00, C_NAP = 2'b01, C_SLP = 2'b10, C_WAK = 2'b11;

  logic [CW-1:0] wake_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  wake_run_q <= '0;
    else if (pwr_mode != C_WAK)  wake_run_q <= '0;
    else if (wake_run_q != '1)   wake_run_q <= wake_run_q + CW'(1);
  end

  p_shdn_forces_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |=> (!ready && !conv_start && (pwr_mode == C_NAP || pwr_mode == C_SLP)));

  p_nap_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!shdn_n && !cs_n) |=> pwr_mode == C_NAP);

  p_sleep_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!shdn_n && cs_n) |=> pwr_mode == C_SLP);

  p_nap_domains_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_mode == C_NAP |-> (ref_en && !bias_en));

  p_sleep_domains_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_mode == C_SLP |-> (!ref_en && !bias_en));

  p_wake_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> wake_run_q >= CW'(NAP_WAKE_CYC));

  p_ready_from_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(pwr_mode) == C_WAK);

  p_done_leads_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |=> pwr_mode == C_ACT);

  p_start_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (ready && start_req));

endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(
  .NAP_WAKE_CYC   (NAP_WAKE_CYC),
  .SLEEP_WAKE_CYC (SLEEP_WAKE_CYC)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .shdn_n     (shdn_n),
  .cs_n       (cs_n),
  .start_req  (start_req),
  .pwr_mode   (pwr_mode),
  .bias_en    (bias_en),
  .ref_en     (ref_en),
  .ready      (ready),
  .conv_start (conv_start),
  .wake_done  (wake_done)
);

// File: tb/pwr_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_tb_top;

  localparam int NAPC = 4;
  localparam int SLPC = 20;
  localparam logic [1:0] M_ACT = 2'b00, M_NAP = 2'b01, M_SLP = 2'b10, M_WAK = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shdn_n = 1'b1;
  logic cs_n = 1'b0;
  logic start_req = 1'b0;
  logic [1:0] pwr_mode;
  logic bias_en, ref_en, ready, conv_start;

  int n_checks = 0;
  int n_err = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [1:0] mode;
    logic       start;
    string      req;
  } exp_t;

  exp_t sb_q[$];

  always #10 clk = ~clk;

  pwr_seq_ctrl #(.NAP_WAKE_CYC(NAPC), .SLEEP_WAKE_CYC(SLPC)) dut_i (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .cs_n(cs_n),
    .start_req(start_req), .pwr_mode(pwr_mode), .bias_en(bias_en),
    .ref_en(ref_en), .ready(ready), .conv_start(conv_start)
  );

  // Expected {ref_en, bias_en, ready} per state, from R3
  function automatic logic [2:0] rbr_of(logic [1:0] m);
    if (m == M_ACT) return 3'b111;
    if (m == M_NAP) return 3'b100;
    if (m == M_SLP) return 3'b000;
    return 3'b110;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: called at a falling edge; applies inputs and queues the state expected after the next rising edge
  task automatic drive(logic sh, logic cs, logic st, logic [1:0] m, string req);
    exp_t e;
    shdn_n = sh; cs_n = cs; start_req = st;
    e.mode = m; e.start = st; e.req = req;
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic run_n(int n, logic sh, logic cs, logic st, logic [1:0] m, string req);
    for (int i = 0; i < n; i++) drive(sh, cs, st, m, req);
  endtask

  // Monitor
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      logic [2:0] r;
      e = sb_q.pop_front();
      r = rbr_of(e.mode);
      chk({e.req, " mode"}, {6'd0, pwr_mode}, {6'd0, e.mode});
      chk({e.req, " ref/bias/ready"}, {5'd0, ref_en, bias_en, ready}, {5'd0, r});
      chk({e.req, " conv_start"}, {7'd0, conv_start}, {7'd0, e.start & r[0]});
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    n_checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    start_req = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state is wake, not ready; R9: request during reset is dropped
    chk("R8 reset mode", {6'd0, pwr_mode}, {6'd0, M_WAK});
    chk("R8 reset ref/bias/ready", {5'd0, ref_en, bias_en, ready}, 8'b110);
    chk("R9 reset conv_start", {7'd0, conv_start}, 8'd0);
    rst_n = 1'b1;
    // R8: cold start takes SLPC edges
    run_n(SLPC - 2, 1, 0, 0, M_WAK, "R8");
    drive(1, 0, 1, M_WAK, "R9");
    drive(1, 0, 1, M_ACT, "R8");
    drive(1, 0, 1, M_ACT, "R9");
    // R4: nap exit with warm reference
    drive(0, 0, 1, M_NAP, "R1");
    drive(0, 0, 0, M_NAP, "R3");
    run_n(NAPC, 1, 0, 1, M_WAK, "R4");
    drive(1, 0, 0, M_ACT, "R4");
    // R5: sleep exit
    drive(0, 1, 0, M_SLP, "R2");
    drive(0, 1, 0, M_SLP, "R3");
    run_n(SLPC, 1, 1, 0, M_WAK, "R5");
    drive(1, 1, 0, M_ACT, "R5");
    // R6: nap wake aborted then restarted with full delay
    drive(0, 0, 0, M_NAP, "R6");
    run_n(2, 1, 0, 0, M_WAK, "R6");
    drive(0, 0, 1, M_NAP, "R6");
    run_n(NAPC, 1, 0, 0, M_WAK, "R6");
    drive(1, 0, 0, M_ACT, "R6");
    // R2 and R7: nap to sleep to nap, then cold exit from nap
    drive(0, 0, 0, M_NAP, "R2");
    drive(0, 1, 0, M_SLP, "R2");
    drive(0, 0, 0, M_NAP, "R2");
    run_n(SLPC, 1, 0, 0, M_WAK, "R7");
    drive(1, 0, 0, M_ACT, "R7");
    // R7: sleep wake aborted into nap stays cold
    drive(0, 1, 0, M_SLP, "R7");
    run_n(5, 1, 0, 0, M_WAK, "R7");
    drive(0, 0, 0, M_NAP, "R6");
    run_n(SLPC, 1, 0, 0, M_WAK, "R7");
    drive(1, 0, 1, M_ACT, "R7");
    start_req = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule